// File: doc/BRIEF.md
# Time-Slotted Static RAM Arbiter

This block lets display refresh and pixel writes share one asynchronous, byte-wide static RAM with no run-time arbitration. A display period of four pixels is one frame. Each frame is split into a fixed number of equal access slots, and each slot is itself split into clock phases. The first three slots of every frame read the three bytes of one packed four-pixel block from the buffer on screen. The remaining slots serve a single pending block write aimed at the hidden buffer. A write is spread over as many write slots as it needs, and may run on into the next frame.

The RAM holds two frame buffers. The top address bit selects the buffer, and the lower bits hold `line * 480 + block * 3 + byte`. A swap request is only noted when it arrives. It is applied at the first frame boundary that follows a vertical-frame marker, so the buffer on screen never changes partway through a picture. The block drives the address, write data with a separate drive enable, and the active-low chip-enable, write-enable and output-enable lines. It returns every fetched byte with a one-cycle strobe.

Top module: `sram_slot_arbiter`

## Requirements
- R1: While reset is held, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` and `pix_valid` are 0, and `wr_ready` is 1.
- R2: A frame is 8 slots of 4 clock cycles each. The first clock edge after reset starts a frame. Slots 0, 1 and 2 read byte 0, 1 and 2 of the block given by `fetch_line`/`fetch_block`, which are sampled at the edge that starts the frame. The read address is `{front, line*480 + block*3 + byte}`, and exactly three bytes are fetched per frame.
- R3: The byte on `sram_dq_i` is captured at the edge that ends each read slot. It is shown on `pix_data` with `pix_valid` high for exactly one cycle, in byte order 0, 1, 2.
- R4: During a read slot, `sram_oe_n` is 0 and `sram_dq_oe` is 0 for all four cycles, and `sram_we_n` stays 1.
- R5: An accepted write stores byte k = `wr_data[8k+7:8k]` at `{~front at acceptance, wr_line*480 + wr_block*3 + k}`. Bytes go out in order 0, 1, 2, one per write slot (slots 3 to 7).
- R6: In a write slot, `sram_we_n` is 0 only in the 2nd and 3rd cycles. `sram_addr` and `sram_dq_o` are held over the whole slot, and `sram_dq_oe` is 1 throughout.
- R7: `wr_ready` is 1 exactly when no block is pending. A block is taken on a cycle with `wr_valid` and `wr_ready` both high, and `wr_ready` falls in the next cycle. Pending writes never move or remove the read slots.
- R8: A `swap_req` pulse flips the displayed buffer at the first frame start after a `frame_start` pulse has been registered. `swap_req` alone does not flip it, and `frame_start` alone does not flip it.
- R9: A write slot with no pending block is idle: `sram_ce_n` stays 1, so a frame without writes has chip-enable low for exactly 12 cycles.
- R10: An accepted block finishes, and `wr_ready` returns to 1, within 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-phase clock (4 cycles per slot) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_line | input | 9 | Line of the next block to display |
| fetch_block | input | 8 | Horizontal block index of the next block to display |
| frame_start | input | 1 | Pulse marking the start of a vertical frame |
| swap_req | input | 1 | Pulse requesting a display/back buffer exchange |
| wr_valid | input | 1 | A packed block write is offered |
| wr_line | input | 9 | Destination line of the offered block |
| wr_block | input | 8 | Destination block index of the offered block |
| wr_data | input | 24 | Three packed bytes, byte 0 in bits 7:0 |
| wr_ready | output | 1 | No block pending; an offered block is taken |
| pix_valid | output | 1 | One-cycle strobe for a fetched byte |
| pix_data | output | 8 | Fetched byte |
| sram_addr | output | 19 | RAM byte address, top bit is the buffer |
| sram_dq_o | output | 8 | Write data toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | 8 | Data read from the RAM |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest case to reach is the handover of the display buffer while a block write is still in progress. The swap request, the vertical marker and the write acceptance must fall in separate frames, and each is sampled at a different point in the 32-cycle schedule. The bench drives every swap and marker pulse at a chosen cycle offset inside a frame that it tracks itself. It also issues writes that span frame boundaries. Each read address, including its buffer bit, is then compared against an independent model of when the flip should have happened.

// File: rtl/sram_arb_pkg.sv
`timescale 1ns/100ps
package sram_arb_pkg;
    typedef enum logic [1:0] {
        SK_IDLE  = 2'd0,
        SK_READ  = 2'd1,
        SK_WRITE = 2'd2
    } slot_kind_e;
endpackage

// File: rtl/slot_timer.sv
`timescale 1ns/100ps
module slot_timer #(
    parameter int SLOTS  = 8,
    parameter int PHASES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [$clog2(SLOTS)-1:0]  slot_cur,
    output logic [$clog2(PHASES)-1:0] phase_cur,
    output logic [$clog2(SLOTS)-1:0]  slot_nxt,
    output logic [$clog2(PHASES)-1:0] phase_nxt,
    output logic                      frame_end
);
    localparam int SW = $clog2(SLOTS);
    localparam int PW = $clog2(PHASES);

    typedef struct packed {
        logic [SW-1:0] slot;
        logic [PW-1:0] phase;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.phase == PW'(PHASES - 1)) begin
            tmr_d.phase = '0;
            tmr_d.slot  = (tmr_q.slot == SW'(SLOTS - 1)) ? '0 : tmr_q.slot + 1'b1;
        end else begin
            tmr_d.phase = tmr_q.phase + 1'b1;
        end
    end

    // Reset parks on the last phase so the first edge opens slot 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.slot  <= SW'(SLOTS - 1);
            tmr_q.phase <= PW'(PHASES - 1);
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign slot_cur  = tmr_q.slot;
    assign phase_cur = tmr_q.phase;
    assign slot_nxt  = tmr_d.slot;
    assign phase_nxt = tmr_d.phase;
    assign frame_end = (tmr_q.slot == SW'(SLOTS - 1)) && (tmr_q.phase == PW'(PHASES - 1));
endmodule

// File: rtl/swap_ctrl.sv
`timescale 1ns/100ps
module swap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic frame_start,
    input  logic frame_end,
    output logic front_cur,
    output logic front_nxt
);
    typedef struct packed {
        logic front;
        logic swap_pend;
        logic vs_seen;
    } swp_t;

    swp_t swp_d, swp_q;

    always_comb begin
        swp_d = swp_q;
        if (swap_req)    swp_d.swap_pend = 1'b1;
        if (frame_start) swp_d.vs_seen   = 1'b1;
        // Flip only at a block boundary after a registered vertical marker.
        if (frame_end && swp_q.vs_seen) begin
            if (swp_q.swap_pend) begin
                swp_d.front     = ~swp_q.front;
                swp_d.swap_pend = swap_req;
            end
            swp_d.vs_seen = frame_start;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) swp_q <= '0;
        else        swp_q <= swp_d;
    end

    assign front_cur = swp_q.front;
    assign front_nxt = swp_d.front;
endmodule

// File: rtl/block_addr.sv
`timescale 1ns/100ps
module block_addr #(
    parameter int LINE_W      = 9,
    parameter int BLK_W       = 8,
    parameter int OFF_W       = 18,
    parameter int LINE_BLOCKS = 160,
    parameter int BLOCK_BYTES = 3
) (
    input  logic [LINE_W-1:0] line,
    input  logic [BLK_W-1:0]  blk,
    output logic [OFF_W-1:0]  base
);
    localparam int LINE_BYTES = LINE_BLOCKS * BLOCK_BYTES;

    always_comb begin
        base = OFF_W'(line) * OFF_W'(LINE_BYTES) + OFF_W'(blk) * OFF_W'(BLOCK_BYTES);
    end
endmodule

// File: rtl/sram_slot_arbiter.sv
`timescale 1ns/100ps
module sram_slot_arbiter
    import sram_arb_pkg::*;
#(
    parameter int SLOTS       = 8,
    parameter int PHASES      = 4,
    parameter int READ_SLOTS  = 3,
    parameter int BLOCK_BYTES = 3,
    parameter int LINE_BLOCKS = 160,
    parameter int LINE_W      = 9,
    parameter int BLK_W       = 8,
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LINE_W-1:0]             fetch_line,
    input  logic [BLK_W-1:0]              fetch_block,
    input  logic                          frame_start,
    input  logic                          swap_req,
    input  logic                          wr_valid,
    input  logic [LINE_W-1:0]             wr_line,
    input  logic [BLK_W-1:0]              wr_block,
    input  logic [BLOCK_BYTES*DATA_W-1:0] wr_data,
    output logic                          wr_ready,
    output logic                          pix_valid,
    output logic [DATA_W-1:0]             pix_data,
    output logic [ADDR_W-1:0]             sram_addr,
    output logic [DATA_W-1:0]             sram_dq_o,
    output logic                          sram_dq_oe,
    input  logic [DATA_W-1:0]             sram_dq_i,
    output logic                          sram_ce_n,
    output logic                          sram_we_n,
    output logic                          sram_oe_n
);
    localparam int SW       = $clog2(SLOTS);
    localparam int PW       = $clog2(PHASES);
    localparam int OFF_W    = ADDR_W - 1;
    localparam int IDX_W    = $clog2(BLOCK_BYTES);
    localparam int WE_FIRST = 1;
    localparam int WE_LAST  = PHASES - 2;

    logic [SW-1:0] slot_cur, slot_nxt;
    logic [PW-1:0] phase_cur, phase_nxt;
    logic          frame_end, front_cur, front_nxt;

    slot_timer #(.SLOTS(SLOTS), .PHASES(PHASES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .slot_cur(slot_cur), .phase_cur(phase_cur),
        .slot_nxt(slot_nxt), .phase_nxt(phase_nxt),
        .frame_end(frame_end)
    );

    swap_ctrl u_swap (
        .clk(clk), .rst_n(rst_n),
        .swap_req(swap_req), .frame_start(frame_start), .frame_end(frame_end),
        .front_cur(front_cur), .front_nxt(front_nxt)
    );

    // Port 0 computes the display block base, port 1 the write block base.
    logic [LINE_W-1:0] ba_line [2];
    logic [BLK_W-1:0]  ba_blk  [2];
    logic [OFF_W-1:0]  ba_base [2];
    assign ba_line[0] = fetch_line;
    assign ba_blk[0]  = fetch_block;
    assign ba_line[1] = wr_line;
    assign ba_blk[1]  = wr_block;

    for (genvar g = 0; g < 2; g++) begin : g_addr
        block_addr #(
            .LINE_W(LINE_W), .BLK_W(BLK_W), .OFF_W(OFF_W),
            .LINE_BLOCKS(LINE_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)
        ) u_ba (
            .line(ba_line[g]), .blk(ba_blk[g]), .base(ba_base[g])
        );
    end

    typedef struct packed {
        slot_kind_e                    kind;
        logic [OFF_W-1:0]              rd_base;
        logic                          wr_pend;
        logic                          wr_buf;
        logic [OFF_W-1:0]              wr_base;
        logic [BLOCK_BYTES*DATA_W-1:0] wr_data;
        logic [IDX_W-1:0]              wr_idx;
        logic [ADDR_W-1:0]             addr;
        logic [DATA_W-1:0]             dq_o;
        logic                          dq_oe;
        logic                          ce_n;
        logic                          we_n;
        logic                          oe_n;
        logic [DATA_W-1:0]             pix;
        logic                          pix_v;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        arb_d       = arb_q;
        arb_d.pix_v = 1'b0;

        if (frame_end) arb_d.rd_base = ba_base[0];

        // Close the slot that ends at this edge.
        if (phase_cur == PW'(PHASES - 1)) begin
            if (arb_q.kind == SK_READ) begin
                arb_d.pix   = sram_dq_i;
                arb_d.pix_v = 1'b1;
            end
            if (arb_q.kind == SK_WRITE) begin
                if (arb_q.wr_idx == IDX_W'(BLOCK_BYTES - 1)) begin
                    arb_d.wr_pend = 1'b0;
                    arb_d.wr_idx  = '0;
                end else begin
                    arb_d.wr_idx  = arb_q.wr_idx + 1'b1;
                end
            end
        end

        if (wr_valid && !arb_q.wr_pend) begin
            arb_d.wr_pend = 1'b1;
            arb_d.wr_buf  = ~front_cur;
            arb_d.wr_base = ba_base[1];
            arb_d.wr_data = wr_data;
            arb_d.wr_idx  = '0;
        end

        // Open the next slot.
        if (phase_nxt == '0) begin
            if (slot_nxt < SW'(READ_SLOTS)) arb_d.kind = SK_READ;
            else if (arb_d.wr_pend)         arb_d.kind = SK_WRITE;
            else                            arb_d.kind = SK_IDLE;
        end

        arb_d.ce_n  = (arb_d.kind == SK_IDLE);
        arb_d.oe_n  = (arb_d.kind != SK_READ);
        arb_d.dq_oe = (arb_d.kind == SK_WRITE);
        arb_d.we_n  = !((arb_d.kind == SK_WRITE) &&
                        (phase_nxt >= PW'(WE_FIRST)) && (phase_nxt <= PW'(WE_LAST)));

        if (arb_d.kind == SK_READ) begin
            arb_d.addr = {front_nxt, arb_d.rd_base + OFF_W'(slot_nxt)};
        end else if (arb_d.kind == SK_WRITE) begin
            arb_d.addr = {arb_d.wr_buf, arb_d.wr_base + OFF_W'(arb_d.wr_idx)};
            arb_d.dq_o = arb_d.wr_data[arb_d.wr_idx*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q      <= '0;
            arb_q.kind <= SK_IDLE;
            arb_q.ce_n <= 1'b1;
            arb_q.we_n <= 1'b1;
            arb_q.oe_n <= 1'b1;
        end else begin
            arb_q <= arb_d;
        end
    end

    assign wr_ready   = !arb_q.wr_pend;
    assign pix_valid  = arb_q.pix_v;
    assign pix_data   = arb_q.pix;
    assign sram_addr  = arb_q.addr;
    assign sram_dq_o  = arb_q.dq_o;
    assign sram_dq_oe = arb_q.dq_oe;
    assign sram_ce_n  = arb_q.ce_n;
    assign sram_we_n  = arb_q.we_n;
    assign sram_oe_n  = arb_q.oe_n;
endmodule

// File: rtl/sram_slot_arbiter_chk.sv
`timescale 1ns/100ps
module sram_slot_arbiter_chk #(
    parameter int SLOTS      = 8,
    parameter int PHASES     = 4,
    parameter int READ_SLOTS = 3,
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              pix_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_o,
    input logic              sram_dq_oe,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n
);
    localparam int WIN = SLOTS * PHASES;
    localparam int WW  = $clog2(WIN);

    logic [WW-1:0] win_q;
    logic [3:0]    pv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            pv_q  <= '0;
        end else if (win_q == WW'(WIN - 1)) begin
            win_q <= '0;
            pv_q  <= '0;
        end else begin
            win_q <= win_q + 1'b1;
            pv_q  <= pv_q + 4'(pix_valid);
        end
    end

    assert_three_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == WW'(WIN - 1)) |-> (4'(pv_q + 4'(pix_valid)) == 4'(READ_SLOTS)));

    assert_pix_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

    assert_bus_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_dq_oe && sram_we_n && !sram_ce_n));

    assert_we_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_dq_o) && $past(sram_dq_oe)));

    assert_we_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_dq_o) && !sram_ce_n && sram_dq_oe));

    assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce_n |-> (sram_we_n && sram_oe_n && !sram_dq_oe));
endmodule

bind sram_slot_arbiter sram_slot_arbiter_chk #(
    .SLOTS(SLOTS), .PHASES(PHASES), .READ_SLOTS(READ_SLOTS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .pix_valid(pix_valid),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
);

// File: tb/sram_slot_arbiter_bench.sv
`timescale 1ns/100ps
module sram_slot_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  fetch_line;
    logic [7:0]  fetch_block;
    logic        frame_start, swap_req, wr_valid;
    logic [8:0]  wr_line;
    logic [7:0]  wr_block;
    logic [23:0] wr_data;
    logic        wr_ready, pix_valid;
    logic [7:0]  pix_data;
    logic [18:0] sram_addr;
    logic [7:0]  sram_dq_o, sram_dq_i;
    logic        sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n;

    always #2.5 clk = ~clk;

    sram_slot_arbiter u_sram_slot_arbiter (
        .clk(clk), .rst_n(rst_n),
        .fetch_line(fetch_line), .fetch_block(fetch_block),
        .frame_start(frame_start), .swap_req(swap_req),
        .wr_valid(wr_valid), .wr_line(wr_line), .wr_block(wr_block), .wr_data(wr_data),
        .wr_ready(wr_ready), .pix_valid(pix_valid), .pix_data(pix_data),
        .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n)
    );

    // RAM model
    logic [7:0] mem [0:524287];
    assign sram_dq_i = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr] : 8'h00;

    typedef struct packed {
        logic [18:0] a;
        logic [7:0]  d;
    } item_t;

    item_t rdq[$];
    item_t wrq[$];

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  exp_front = 1'b0;
    bit  exp_front_cur = 1'b0;
    bit  m_swap = 1'b0;
    bit  m_vs = 1'b0;
    logic [18:0] last_rd_addr = '0;
    int  we_low = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Read monitor: compare each strobed byte and the address its slot used.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (pix_valid === 1'b1) begin
                if (rdq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected pix_valid", 1, 0);
                end else begin
                    item_t e;
                    e = rdq.pop_front();
                    chk(last_rd_addr == e.a, "R2", "read address", last_rd_addr, e.a);
                    chk(pix_data == e.d, "R3", "read byte", pix_data, e.d);
                end
            end
            if (sram_oe_n === 1'b0) last_rd_addr = sram_addr;
            if (sram_we_n === 1'b0) we_low++;
        end
    end

    // Write monitor: the RAM latches on the rising write enable.
    always @(posedge sram_we_n) begin
        if (rst_n === 1'b1 && sram_ce_n === 1'b0) begin
            mem[sram_addr] = sram_dq_o;
            if (wrq.size() == 0) begin
                chk(1'b0, "R5", "unexpected write", sram_addr, 0);
            end else begin
                item_t e;
                e = wrq.pop_front();
                chk(sram_addr == e.a, "R5", "write address", sram_addr, e.a);
                chk(sram_dq_o == e.d, "R5", "write byte", sram_dq_o, e.d);
            end
            chk(we_low == 2, "R6", "write strobe width", we_low, 2);
            we_low = 0;
        end
    end

    // One 32-cycle frame, entered and left at the falling edge before a frame start.
    task automatic run_frame(input int line, input int blk, input int sw_at,
                             input int vs_at, input bit idle_chk);
        int ce_cnt = 0;
        int off;
        if (m_vs) begin
            if (m_swap) begin
                exp_front = ~exp_front;
                m_swap = 1'b0;
            end
            m_vs = 1'b0;
        end
        fetch_line  = 9'(line);
        fetch_block = 8'(blk);
        off = line * 480 + blk * 3;
        for (int i = 0; i < 3; i++) begin
            item_t e;
            e.a = {exp_front, 18'(off + i)};
            e.d = mem[e.a];
            rdq.push_back(e);
        end
        for (int k = 0; k < 32; k++) begin
            @(posedge clk);
            if (k == 0) exp_front_cur = exp_front;
            @(negedge clk);
            swap_req    = (k == sw_at);
            frame_start = (k == vs_at);
            if (k == sw_at) m_swap = 1'b1;
            if (k == vs_at) m_vs = 1'b1;
            if (sram_ce_n === 1'b0) ce_cnt++;
        end
        if (idle_chk) chk(ce_cnt == 12, "R9", "chip-enable cycles in idle frame", ce_cnt, 12);
    endtask

    task automatic do_write(input int line, input int blk, input logic [23:0] data);
        int off;
        int lat;
        wr_line  = 9'(line);
        wr_block = 8'(blk);
        wr_data  = data;
        wr_valid = 1'b1;
        while (wr_ready !== 1'b1) @(negedge clk);
        off = line * 480 + blk * 3;
        for (int i = 0; i < 3; i++) begin
            item_t e;
            e.a = {~exp_front_cur, 18'(off + i)};
            e.d = data[8*i +: 8];
            wrq.push_back(e);
        end
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wr_ready == 1'b0, "R7", "ready after acceptance", wr_ready, 0);
        lat = 1;
        while (wr_ready !== 1'b1 && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk(lat <= 64, "R10", "block write latency", lat, 64);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 524288; i++) mem[i] = 8'(i ^ (i >> 8) ^ (i >> 16));
        rst_n = 1'b0;
        fetch_line = '0; fetch_block = '0; frame_start = 1'b0; swap_req = 1'b0;
        wr_valid = 1'b0; wr_line = '0; wr_block = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        // R1: idle pins during reset
        chk(sram_ce_n == 1'b1, "R1", "ce_n in reset", sram_ce_n, 1);
        chk(sram_we_n == 1'b1, "R1", "we_n in reset", sram_we_n, 1);
        chk(sram_oe_n == 1'b1, "R1", "oe_n in reset", sram_oe_n, 1);
        chk(sram_dq_oe == 1'b0, "R1", "dq_oe in reset", sram_dq_oe, 0);
        chk(pix_valid == 1'b0, "R1", "pix_valid in reset", pix_valid, 0);
        chk(wr_ready == 1'b1, "R1", "wr_ready in reset", wr_ready, 1);
        rst_n = 1'b1;
        fork
            begin
                run_frame(0, 0, -1, -1, 1'b1);
                run_frame(479, 159, -1, -1, 1'b1);
                run_frame(2, 1, -1, -1, 1'b0);
                run_frame(3, 40, -1, -1, 1'b0);
                run_frame(4, 80, -1, -1, 1'b0);
                run_frame(5, 120, -1, -1, 1'b0);
                run_frame(6, 150, -1, -1, 1'b0);
                run_frame(7, 7, -1, -1, 1'b0);
                run_frame(20, 20, 5, -1, 1'b0);     // R8: swap noted, no marker yet
                run_frame(20, 20, -1, 7, 1'b0);     // still old buffer; marker arms flip
                run_frame(10, 5, -1, 3, 1'b0);      // new buffer; marker alone
                run_frame(479, 159, -1, -1, 1'b0);  // no flip from lone marker
                run_frame(10, 6, 2, 20, 1'b0);      // swap and marker in one frame
                run_frame(10, 6, -1, -1, 1'b0);     // flipped back
                run_frame(0, 0, -1, -1, 1'b1);
            end
            begin
                repeat (70) @(negedge clk);
                do_write(10, 5, 24'hA1B2C3);
                do_write(10, 6, 24'h0F1E2D);
                repeat (5) @(negedge clk);
                do_write(479, 159, 24'h3C2B1A);
            end
        join
        repeat (4) @(negedge clk);
        chk(rdq.size() == 0, "R2", "fetches left over", rdq.size(), 0);
        chk(wrq.size() == 0, "R5", "writes left over", wrq.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule